// File: doc/BRIEF.md
# Dependency Graph IR Builder

This block takes the decoded instructions of one basic block, one at a time and in program order. It builds a fixed-layout dependency graph for a downstream instruction scheduler. Each instruction gets one 128-bit record at an index equal to its position in the block. The record holds the operation code, the destination and three source register numbers, three edge counters and a list of up to eight successor indices. No pointers are stored, so any record is reached by direct indexing. The block reads records back through an index port.

Three tracking tables are kept while instructions arrive: the most recent writer of each register, the most recent reader of each register, and the most recent store. For every new instruction the block derives its candidate predecessors from these tables. Candidates that name the same predecessor are merged. The block then links the new instruction into each predecessor's successor list, one edge per cycle. A pulse on `blk_end` closes the block. It raises `blk_done` for one cycle once the last record is written, and it clears the tables so that no edge crosses into the next block.

Top module: `depgraph_builder`

## Requirements
- R1: Record layout. Bits [127:120] hold the opcode. Bits [119:116] hold the successor count and bits [115:112] the data-successor count. Bits [111:104] hold the dependency count. Bit 97 is the store flag and bit 96 the load flag. Bits [95:88], [87:80], [79:72] and [71:64] hold the destination and sources a, b and c, each zero-extended to 8 bits. Successor slot s sits at bits [8s+7:8s]. After reset every record reads zero.
- R2: For each non-zero source register, an instruction depends on the latest earlier instruction of the block that wrote that register. Such a true-data edge also raises the predecessor's data-successor count.
- R3: For a non-zero destination, an instruction depends on the latest earlier writer and on the latest earlier reader of that register. These ordering edges do not raise the data-successor count.
- R4: Loads and stores depend on the latest earlier store of the block. Loads are never ordered against other loads.
- R5: Register 0 never produces an edge, either as a source or as a destination.
- R6: When several rules name the same predecessor, only one edge is recorded. That edge counts as data if any of the rules is a true-data one.
- R7: Successors are appended in program order. Each recorded edge adds one to the predecessor's successor count and one to the consumer's dependency count.
- R8: An edge whose predecessor already lists eight successors is dropped and counted nowhere. `blk_ovf` is then set and held until the first instruction of the next block is accepted.
- R9: An instruction is taken on a cycle where both `in_valid` and `in_ready` are high. `in_ready` is low while an instruction is being linked, and low after 256 instructions until the block is closed.
- R10: After a `blk_end` pulse, which may arrive while an instruction is still being linked, `blk_done` is high for exactly one cycle after the final record is written. `blk_len` then gives the instruction count, and the next block sees none of the previous block's writers, readers or stores.
- R11: Right after reset, `in_ready` is high and `blk_done`, `blk_ovf` and `blk_len` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Builder can take an instruction |
| in_op | input | 8 | Operation code |
| in_dst | input | 6 | Destination register |
| in_srcs | input | 18 | Sources: a at [5:0], b at [11:6], c at [17:12] |
| in_load | input | 1 | Instruction reads memory |
| in_store | input | 1 | Instruction writes memory |
| blk_end | input | 1 | Close the current block (pulse) |
| blk_done | output | 1 | One-cycle pulse: block complete |
| blk_ovf | output | 1 | A successor edge was dropped in this block |
| blk_len | output | 9 | Instructions in the current or last block |
| rd_idx | input | 8 | Record index to read |
| rd_entry | output | 128 | Record at `rd_idx` (combinational) |

## Verification
A stale or wrong entry in the last-writer, last-reader or last-store table does not show at once. It shows in the first later record of the same block that names that register or touches memory: that record's dependency count is off, and so is the predecessor's successor list. A fault can therefore stay hidden until the block is read back, so every block is read back in full and compared. The table clear on close is exposed by the next block's first dependent instruction. A broken successor-slot limit shows as `blk_ovf` staying low, and as the ninth and later consumers still reporting a dependency.

// File: rtl/dg_pkg.sv
package dg_pkg;
  localparam int IDX_W    = 8;
  localparam int FLD_W    = 8;
  localparam int NSRC     = 3;
  localparam int SUCC_MAX = 8;
  localparam int SLOT_W   = $clog2(SUCC_MAX);
  localparam int CNT_W    = SLOT_W + 1;
  localparam int NCAND    = NSRC + 3;  // sources, then WAW, WAR, memory

  typedef struct packed {
    logic [7:0]                        op;
    logic [CNT_W-1:0]                  n_succ;
    logic [CNT_W-1:0]                  n_dsucc;
    logic [7:0]                        n_dep;
    logic [5:0]                        kind_pad;
    logic                              is_st;
    logic                              is_ld;
    logic [FLD_W-1:0]                  r_dst;
    logic [FLD_W-1:0]                  r_a;
    logic [FLD_W-1:0]                  r_b;
    logic [FLD_W-1:0]                  r_c;
    logic [SUCC_MAX-1:0][IDX_W-1:0]    succ;
  } entry_t;

  typedef struct packed {
    logic             vld;
    logic             data;
    logic [IDX_W-1:0] pred;
  } cand_t;

  typedef cand_t [NCAND-1:0] cand_vec_t;

  function automatic logic list_full(entry_t e);
    return e.n_succ >= CNT_W'(SUCC_MAX);
  endfunction

  // Append one successor to a record whose list still has room.
  function automatic entry_t link_succ(entry_t e, logic [IDX_W-1:0] who, logic is_data);
    entry_t r;
    r = e;
    r.succ[e.n_succ[SLOT_W-1:0]] = who;
    r.n_succ = e.n_succ + CNT_W'(1);
    if (is_data) r.n_dsucc = e.n_dsucc + CNT_W'(1);
    return r;
  endfunction

  function automatic entry_t fresh_entry(logic [7:0] op, logic [7:0] dep, logic ld, logic st,
                                         logic [FLD_W-1:0] d, logic [FLD_W-1:0] a,
                                         logic [FLD_W-1:0] b, logic [FLD_W-1:0] c);
    entry_t r;
    r = '0;
    r.op = op;
    r.n_dep = dep;
    r.is_ld = ld;
    r.is_st = st;
    r.r_dst = d;
    r.r_a = a;
    r.r_b = b;
    r.r_c = c;
    return r;
  endfunction

  // Keep the first candidate naming each predecessor. Source slots come first,
  // so a merged edge is marked data whenever any source rule named it.
  function automatic cand_vec_t merge_dups(cand_vec_t raw);
    cand_vec_t o;
    o = raw;
    for (int k = 1; k < NCAND; k++)
      for (int j = 0; j < k; j++)
        if (raw[j].vld && raw[k].vld && raw[j].pred == raw[k].pred) o[k].vld = 1'b0;
    return o;
  endfunction
endpackage

// File: rtl/dg_last_use.sv
module dg_last_use import dg_pkg::*; #(
  parameter int NREG = 64,
  localparam int RW  = $clog2(NREG)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  upd,
  input  logic [IDX_W-1:0]      upd_idx,
  input  logic [RW-1:0]         upd_dst,
  input  logic [NSRC*RW-1:0]    upd_srcs,
  input  logic                  upd_store,
  input  logic [RW-1:0]         q_dst,
  input  logic [NSRC*RW-1:0]    q_srcs,
  output logic [NSRC-1:0]             src_w_vld,
  output logic [NSRC-1:0][IDX_W-1:0]  src_w_idx,
  output logic                  dst_w_vld,
  output logic [IDX_W-1:0]      dst_w_idx,
  output logic                  dst_r_vld,
  output logic [IDX_W-1:0]      dst_r_idx,
  output logic                  st_vld,
  output logic [IDX_W-1:0]      st_idx
);
  logic [NREG-1:0]  wr_v, rd_v;
  logic [IDX_W-1:0] wr_i [NREG];
  logic [IDX_W-1:0] rd_i [NREG];
  logic             st_v;
  logic [IDX_W-1:0] st_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_v <= '0;
      rd_v <= '0;
      st_v <= 1'b0;
      st_i <= '0;
      for (int r = 0; r < NREG; r++) begin
        wr_i[r] <= '0;
        rd_i[r] <= '0;
      end
    end else if (clr) begin
      wr_v <= '0;
      rd_v <= '0;
      st_v <= 1'b0;
    end else if (upd) begin
      for (int g = 0; g < NSRC; g++) begin
        if (upd_srcs[g*RW +: RW] != '0) begin
          rd_v[upd_srcs[g*RW +: RW]] <= 1'b1;
          rd_i[upd_srcs[g*RW +: RW]] <= upd_idx;
        end
      end
      if (upd_dst != '0) begin
        wr_v[upd_dst] <= 1'b1;
        wr_i[upd_dst] <= upd_idx;
      end
      if (upd_store) begin
        st_v <= 1'b1;
        st_i <= upd_idx;
      end
    end
  end

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_srcq
      assign src_w_vld[g] = wr_v[q_srcs[g*RW +: RW]];
      assign src_w_idx[g] = wr_i[q_srcs[g*RW +: RW]];
    end
  endgenerate

  assign dst_w_vld = wr_v[q_dst];
  assign dst_w_idx = wr_i[q_dst];
  assign dst_r_vld = rd_v[q_dst];
  assign dst_r_idx = rd_i[q_dst];
  assign st_vld    = st_v;
  assign st_idx    = st_i;

  AST_CLEAR_FORGETS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (wr_v == '0 && rd_v == '0 && !st_v)) else $error("tables survive block close"); // R10
  AST_R0_UNTRACKED: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (!wr_v[0] && !rd_v[0])) else $error("register 0 tracked"); // R5
endmodule

// File: rtl/dg_edge_pick.sv
module dg_edge_pick import dg_pkg::*; (
  input  logic [NSRC-1:0]             src_w_vld,
  input  logic [NSRC-1:0][IDX_W-1:0]  src_w_idx,
  input  logic                        dst_w_vld,
  input  logic [IDX_W-1:0]            dst_w_idx,
  input  logic                        dst_r_vld,
  input  logic [IDX_W-1:0]            dst_r_idx,
  input  logic                        is_mem,
  input  logic                        st_vld,
  input  logic [IDX_W-1:0]            st_idx,
  output cand_vec_t                   cands
);
  cand_vec_t raw;

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_raw
      assign raw[g] = '{vld: src_w_vld[g], data: 1'b1, pred: src_w_idx[g]};
    end
  endgenerate

  assign raw[NSRC]   = '{vld: dst_w_vld, data: 1'b0, pred: dst_w_idx};
  assign raw[NSRC+1] = '{vld: dst_r_vld, data: 1'b0, pred: dst_r_idx};
  assign raw[NSRC+2] = '{vld: is_mem && st_vld, data: 1'b0, pred: st_idx};

  assign cands = merge_dups(raw);
endmodule

// File: rtl/dg_entry_store.sv
module dg_entry_store import dg_pkg::*; #(
  parameter int DEPTH = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] w_idx,
  input  entry_t           w_data,
  input  logic [IDX_W-1:0] m_idx,
  output entry_t           m_data,
  input  logic [IDX_W-1:0] r_idx,
  output entry_t           r_data
);
  entry_t mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[w_idx] <= w_data;
    end
  end

  assign m_data = mem_q[m_idx];
  assign r_data = mem_q[r_idx];

  AST_SUCC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (w_data.n_succ <= CNT_W'(SUCC_MAX))) else $error("successor list overrun"); // R8
  AST_DATA_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (w_data.n_dsucc <= w_data.n_succ)) else $error("data count above total"); // R7
endmodule

// File: rtl/depgraph_builder.sv
module depgraph_builder import dg_pkg::*; #(
  parameter int DEPTH = 256,
  parameter int NREG  = 64,
  localparam int RW    = $clog2(NREG),
  localparam int LEN_W = $clog2(DEPTH + 1),
  localparam int KW    = $clog2(NCAND)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [7:0]             in_op,
  input  logic [RW-1:0]          in_dst,
  input  logic [NSRC*RW-1:0]     in_srcs,
  input  logic                   in_load,
  input  logic                   in_store,
  input  logic                   blk_end,
  output logic                   blk_done,
  output logic                   blk_ovf,
  output logic [LEN_W-1:0]       blk_len,
  input  logic [IDX_W-1:0]       rd_idx,
  output logic [8*16-1:0]        rd_entry
);
  typedef enum logic [1:0] {S_IDLE, S_EDGE, S_COMMIT} state_e;

  state_e            st_q;
  logic [KW-1:0]     k_q;
  cand_vec_t         cand_q, cand_d;
  logic [IDX_W-1:0]  cur_q;
  logic [7:0]        op_q, dep_q;
  logic [RW-1:0]     dst_q;
  logic [NSRC*RW-1:0] srcs_q;
  logic              ld_q, sto_q;
  logic [LEN_W-1:0]  n_q;
  logic              fresh_q, pend_q, done_q, ovf_q;

  // named events
  logic acc, finish, commit, link_ok, link_drop, full;
  cand_t cand_cur;
  logic [IDX_W-1:0] slot;

  // tracker outputs
  logic [NSRC-1:0]            src_w_vld;
  logic [NSRC-1:0][IDX_W-1:0] src_w_idx;
  logic dst_w_vld, dst_r_vld, st_vld;
  logic [IDX_W-1:0] dst_w_idx, dst_r_idx, st_idx;

  entry_t m_data, r_data, w_data;
  logic   we;
  logic [IDX_W-1:0] w_idx;

  assign full     = !fresh_q && (n_q == LEN_W'(DEPTH));
  assign in_ready = (st_q == S_IDLE) && !pend_q && !full;
  assign acc      = in_valid && in_ready;
  assign finish   = (st_q == S_IDLE) && pend_q && !done_q;
  assign commit   = (st_q == S_COMMIT);
  assign slot     = fresh_q ? '0 : n_q[IDX_W-1:0];
  assign cand_cur = cand_q[k_q];
  assign link_ok  = (st_q == S_EDGE) && cand_cur.vld && !list_full(m_data);
  assign link_drop = (st_q == S_EDGE) && cand_cur.vld && list_full(m_data);

  dg_last_use #(.NREG(NREG)) u_track (
    .clk, .rst_n, .clr(finish), .upd(commit), .upd_idx(cur_q), .upd_dst(dst_q),
    .upd_srcs(srcs_q), .upd_store(sto_q), .q_dst(in_dst), .q_srcs(in_srcs),
    .src_w_vld, .src_w_idx, .dst_w_vld, .dst_w_idx, .dst_r_vld, .dst_r_idx,
    .st_vld, .st_idx
  );

  dg_edge_pick u_pick (
    .src_w_vld, .src_w_idx, .dst_w_vld, .dst_w_idx, .dst_r_vld, .dst_r_idx,
    .is_mem(in_load || in_store), .st_vld, .st_idx, .cands(cand_d)
  );

  always_comb begin
    we = 1'b0;
    w_idx = cand_cur.pred;
    w_data = link_succ(m_data, cur_q, cand_cur.data);
    if (link_ok) begin
      we = 1'b1;
    end else if (commit) begin
      we = 1'b1;
      w_idx = cur_q;
      w_data = fresh_entry(op_q, dep_q, ld_q, sto_q, FLD_W'(dst_q), FLD_W'(srcs_q[0 +: RW]),
                           FLD_W'(srcs_q[RW +: RW]), FLD_W'(srcs_q[2*RW +: RW]));
    end
  end

  dg_entry_store #(.DEPTH(DEPTH)) u_store (
    .clk, .rst_n, .we, .w_idx, .w_data, .m_idx(cand_cur.pred), .m_data,
    .r_idx(rd_idx), .r_data
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      k_q <= '0;
      cand_q <= '0;
      cur_q <= '0;
      op_q <= '0;
      dep_q <= '0;
      dst_q <= '0;
      srcs_q <= '0;
      ld_q <= 1'b0;
      sto_q <= 1'b0;
      n_q <= '0;
      fresh_q <= 1'b1;
      pend_q <= 1'b0;
      done_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (blk_end) pend_q <= 1'b1;
      else if (finish) pend_q <= 1'b0;
      if (finish) fresh_q <= 1'b1;
      unique case (st_q)
        S_IDLE: if (acc) begin
          st_q <= S_EDGE;
          k_q <= '0;
          cand_q <= cand_d;
          cur_q <= slot;
          op_q <= in_op;
          dst_q <= in_dst;
          srcs_q <= in_srcs;
          ld_q <= in_load;
          sto_q <= in_store;
          dep_q <= '0;
          n_q <= LEN_W'(slot) + LEN_W'(1);
          fresh_q <= 1'b0;
          if (fresh_q) ovf_q <= 1'b0;
        end
        S_EDGE: begin
          if (link_ok) dep_q <= dep_q + 8'd1;
          if (link_drop) ovf_q <= 1'b1;
          if (k_q == KW'(NCAND - 1)) st_q <= S_COMMIT;
          else k_q <= k_q + KW'(1);
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign blk_done = done_q;
  assign blk_ovf  = ovf_q;
  assign blk_len  = n_q;
  assign rd_entry = r_data;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> !blk_done) else $error("done longer than one cycle"); // R10
  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !in_ready) else $error("ready while linking"); // R9
  AST_PRED_OLDER: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_EDGE && cand_cur.vld) |-> (cand_cur.pred < cur_q)) else $error("edge to younger"); // R2
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_ovf && !acc) |=> blk_ovf) else $error("overflow flag lost"); // R8
  AST_DEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (dep_q <= 8'(NCAND))) else $error("dependency count too high"); // R7
  AST_R0_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_dst == '0) |-> (!cand_d[NSRC].vld && !cand_d[NSRC+1].vld)) else $error("r0 edge"); // R5
endmodule

// File: tb/sim_depgraph_builder.sv
module sim_depgraph_builder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_load = 1'b0, in_store = 1'b0;
  logic [7:0] in_op = '0;
  logic [5:0] in_dst = '0;
  logic [17:0] in_srcs = '0;
  logic blk_end = 1'b0, blk_done, blk_ovf;
  logic [8:0] blk_len;
  logic [7:0] rd_idx = '0;
  logic [127:0] rd_entry;

  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  depgraph_builder u0 (.*);

  // bench-side record of the current block
  int n_ins = 0;
  logic [7:0] b_op [256];
  logic [5:0] b_d [256], b_a [256], b_b [256], b_c [256];
  logic b_ld [256], b_st [256];
  int e_ns [256], e_nd [256], e_dep [256];
  logic [63:0] e_sl [256];
  logic m_ovf;

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int last_wr(int j, logic [5:0] r);
    for (int i = j - 1; i >= 0; i--) if (b_d[i] == r) return i;
    return -1;
  endfunction

  function automatic int last_rd(int j, logic [5:0] r);
    for (int i = j - 1; i >= 0; i--) if (b_a[i] == r || b_b[i] == r || b_c[i] == r) return i;
    return -1;
  endfunction

  function automatic int last_st(int j);
    for (int i = j - 1; i >= 0; i--) if (b_st[i]) return i;
    return -1;
  endfunction

  task automatic build_model();
    m_ovf = 1'b0;
    for (int i = 0; i < 256; i++) begin
      e_ns[i] = 0; e_nd[i] = 0; e_dep[i] = 0; e_sl[i] = '0;
    end
    for (int j = 0; j < n_ins; j++) begin
      logic [255:0] pm, pd;
      logic [5:0] sv [3];
      int w;
      pm = '0; pd = '0;
      sv[0] = b_a[j]; sv[1] = b_b[j]; sv[2] = b_c[j];
      for (int k = 0; k < 3; k++) begin
        if (sv[k] != 0) begin
          w = last_wr(j, sv[k]);
          if (w >= 0) begin pm[w] = 1'b1; pd[w] = 1'b1; end
        end
      end
      if (b_d[j] != 0) begin
        w = last_wr(j, b_d[j]); if (w >= 0) pm[w] = 1'b1;
        w = last_rd(j, b_d[j]); if (w >= 0) pm[w] = 1'b1;
      end
      if (b_ld[j] || b_st[j]) begin
        w = last_st(j); if (w >= 0) pm[w] = 1'b1;
      end
      for (int i = 0; i < j; i++) begin
        if (pm[i]) begin
          if (e_ns[i] < 8) begin
            e_sl[i][e_ns[i]*8 +: 8] = 8'(j);
            e_ns[i]++;
            if (pd[i]) e_nd[i]++;
            e_dep[j]++;
          end else m_ovf = 1'b1;
        end
      end
    end
  endtask

  function automatic logic [127:0] exp_entry(int i);
    return {b_op[i], 4'(e_ns[i]), 4'(e_nd[i]), 8'(e_dep[i]), 6'd0, b_st[i], b_ld[i],
            2'b0, b_d[i], 2'b0, b_a[i], 2'b0, b_b[i], 2'b0, b_c[i], e_sl[i]};
  endfunction

  task automatic add(logic [7:0] op, logic [5:0] d, logic [5:0] a, logic [5:0] b,
                     logic [5:0] c, logic ld, logic st);
    b_op[n_ins] = op; b_d[n_ins] = d; b_a[n_ins] = a; b_b[n_ins] = b; b_c[n_ins] = c;
    b_ld[n_ins] = ld; b_st[n_ins] = st;
    n_ins++;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_op = op; in_dst = d; in_srcs = {c, b, a};
    in_load = ld; in_store = st;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // close the block, then compare flags, length and every record
  task automatic close_and_check(string tag, bit now);
    if (!now) @(negedge clk);
    blk_end = 1'b1;
    @(negedge clk);
    blk_end = 1'b0;
    while (!blk_done) @(negedge clk);
    @(negedge clk);
    chk("R10 done width", 128'(blk_done), 128'(0));
    build_model();
    chk("R10 length", 128'(blk_len), 128'(n_ins));
    chk("R8 overflow flag", 128'(blk_ovf), 128'(m_ovf));
    for (int i = 0; i < n_ins; i++) begin
      rd_idx = 8'(i);
      #1;
      chk(tag, rd_entry, exp_entry(i));
    end
    n_ins = 0;
  endtask

  task automatic t_reset();
    rd_idx = 8'd0;
    #1;
    chk("R11 ready", 128'(in_ready), 128'(1));
    chk("R11 done", 128'(blk_done), 128'(0));
    chk("R11 ovf", 128'(blk_ovf), 128'(0));
    chk("R11 len", 128'(blk_len), 128'(0));
    chk("R1 record after reset", rd_entry, 128'(0));
  endtask

  task automatic t_raw();
    add(8'h11, 6'd1, 6'd0, 6'd0, 6'd0, 0, 0);
    add(8'h12, 6'd2, 6'd1, 6'd0, 6'd0, 0, 0);
    add(8'h13, 6'd3, 6'd1, 6'd2, 6'd0, 0, 0);
    add(8'h14, 6'd4, 6'd9, 6'd3, 6'd1, 0, 0);
    close_and_check("R2 true-data edges (R1 layout)", 0);
  endtask

  task automatic t_order();
    add(8'h21, 6'd5, 6'd6, 6'd0, 6'd0, 0, 0);
    add(8'h22, 6'd6, 6'd0, 6'd0, 6'd0, 0, 0);
    add(8'h23, 6'd5, 6'd0, 6'd0, 6'd0, 0, 0);
    add(8'h24, 6'd7, 6'd5, 6'd0, 6'd0, 0, 0);
    add(8'h25, 6'd5, 6'd0, 6'd0, 6'd0, 0, 0);
    close_and_check("R3 WAR/WAW edges", 0);
  endtask

  task automatic t_mem();
    add(8'h31, 6'd1, 6'd0, 6'd0, 6'd0, 1, 0);
    add(8'h32, 6'd2, 6'd0, 6'd0, 6'd0, 1, 0);
    add(8'h33, 6'd0, 6'd3, 6'd0, 6'd0, 0, 1);
    add(8'h34, 6'd4, 6'd0, 6'd0, 6'd0, 1, 0);
    add(8'h35, 6'd0, 6'd8, 6'd0, 6'd0, 0, 1);
    add(8'h36, 6'd9, 6'd0, 6'd0, 6'd0, 1, 0);
    close_and_check("R4 memory ordering", 0);
  endtask

  task automatic t_r0();
    add(8'h41, 6'd0, 6'd0, 6'd0, 6'd0, 0, 0);
    add(8'h42, 6'd0, 6'd0, 6'd0, 6'd0, 0, 0);
    add(8'h43, 6'd3, 6'd0, 6'd0, 6'd0, 0, 0);
    add(8'h44, 6'd0, 6'd0, 6'd0, 6'd0, 0, 0);
    close_and_check("R5 register zero", 0);
  endtask

  task automatic t_dup();
    add(8'h51, 6'd4, 6'd0, 6'd0, 6'd0, 0, 1);
    add(8'h52, 6'd4, 6'd4, 6'd4, 6'd4, 0, 1);
    add(8'h53, 6'd4, 6'd0, 6'd0, 6'd0, 0, 0);
    close_and_check("R6 merged edges", 0);
  endtask

  task automatic t_overflow();
    add(8'h61, 6'd1, 6'd0, 6'd0, 6'd0, 0, 0);
    for (int i = 0; i < 10; i++) add(8'(8'h70 + i), 6'd0, 6'd1, 6'd0, 6'd0, 0, 0);
    close_and_check("R8 successor overflow (R7 order)", 0);
    // next block: flag clears on first accept, no cross-block edges
    add(8'h62, 6'd2, 6'd1, 6'd0, 6'd0, 0, 0);
    chk("R8 ovf cleared", 128'(blk_ovf), 128'(0));
    add(8'h63, 6'd0, 6'd0, 6'd0, 6'd0, 1, 0);
    close_and_check("R10 fresh tables", 0);
  endtask

  task automatic t_end_busy();
    add(8'h81, 6'd3, 6'd0, 6'd0, 6'd0, 0, 1);
    add(8'h82, 6'd0, 6'd3, 6'd0, 6'd0, 1, 0);
    close_and_check("R10 close while linking", 1);
  endtask

  task automatic t_full();
    for (int i = 0; i < 256; i++)
      add(8'(i), 6'((i % 63) + 1), (i > 0) ? 6'(((i - 1) % 63) + 1) : 6'd0, 6'd0, 6'd0, 0, 0);
    repeat (12) @(negedge clk);
    chk("R9 ready low when full", 128'(in_ready), 128'(0));
    close_and_check("R9 full block", 0);
    chk("R9 ready after close", 128'(in_ready), 128'(1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_raw();
    t_order();
    t_mem();
    t_r0();
    t_dup();
    t_overflow();
    t_end_busy();
    t_full();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule